// File: doc/BRIEF.md
# Mode-Selectable Input Word Buffer

This block is the input stage in front of a parallel-to-serial pixel shifter. It takes a data word from a host bus on rising edges of a write strobe. On each rising edge of a load request it hands one word to the shifter's parallel-load inputs. Two mode pins choose how words are held between the two strobes. The first choice is a four-deep first-in-first-out queue that overwrites its oldest entry when it overflows. The second is a single edge-triggered word register. The third is a transparent latch that passes the input straight through while the write strobe is low.

Both strobes and both mode pins are level inputs sampled by one system clock, and the block finds their edges itself. The delivered word sits in an output register. It changes only on a load request, and a one-cycle pulse marks each delivery. In queue mode the pointers are cleared by a short low pulse on the second mode pin. The load request must already be high when that pulse begins.

Top module: `word_input_buffer`

## Requirements
- R1: After reset `load_word` is 0, `load_pulse` is 0 and the queue is empty.
- R2: Mode encoding is {mode_a, mode_b}. 2'b11 selects the queue, 2'b10 selects the transparent latch, and 2'b00 selects the single word register. The unused code 2'b01 behaves as the single word register.
- R3: In queue mode each rising write edge stores `wr_data`. Each rising load edge then delivers the oldest stored word. `load_word` shows it from the clock edge that samples the load rise.
- R4: In queue mode a write while four words are held replaces the oldest word. The next four reads return the four most recent writes, oldest first.
- R5: In queue mode a load edge while the queue is empty leaves `load_word` unchanged. This also holds when a write happens in the same cycle. That write is still stored and is delivered by the next load edge.
- R6: In queue mode, a fall of `mode_b` while `load_req` is high empties the queue. The same fall while `load_req` is low leaves the queue contents intact.
- R7: In single word mode a rising write edge captures `wr_data` and a load edge delivers the captured word. A load edge in the same cycle as a write delivers the previous word.
- R8: In transparent mode, while `wr_strobe` is low, a load edge delivers the `wr_data` present at that clock edge.
- R9: In transparent mode, after `wr_strobe` rises, load edges deliver the word present at the last clock edge before the rise, whatever `wr_data` does afterwards.
- R10: Only rising edges act. A strobe held high for several cycles causes one write or one load.
- R11: `load_pulse` is high for exactly the one cycle after the clock edge that samples a load rise. `load_word` changes only together with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_a | input | 1 | Mode select bit 1 |
| mode_b | input | 1 | Mode select bit 0; its low pulse clears the queue |
| wr_strobe | input | 1 | Write strobe (level, rising edge acts) |
| wr_data | input | W | Input word |
| load_req | input | 1 | Load request to the shifter (level, rising edge acts) |
| load_word | output | W | Word presented to the shifter parallel inputs |
| load_pulse | output | 1 | One-cycle marker of a delivery |

## Verification
Each result of this block is due one clock edge after the stimulus. A write or load rise is sampled at the next rising edge, and the delivered word and its pulse are visible right after that same edge. A queue clear takes effect at the edge that samples the fall of `mode_b`. The bench drives every input on the falling edge and compares outputs on the following falling edge, half a period after the edge that produced them. This keeps every comparison clear of the active edge. Multi-cycle effects are checked step by step rather than in one window: a held strobe, a latch that stays closed, and the refill after an overflow.

// File: rtl/wib_pkg.sv
// Shared types for the input word buffer.
// Assumes: the two mode pins are stable or change only between clock edges.
package wib_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_FIFO   = 2'd1,
        MODE_TRANSP = 2'd2
    } wib_mode_e;

    // Maps the mode pin pair to an operating mode; the unused code falls to single.
    function automatic wib_mode_e wib_decode(input logic sel_a, input logic sel_b);
        wib_mode_e m;
        case ({sel_a, sel_b})
            2'b11:   m = MODE_FIFO;
            2'b10:   m = MODE_TRANSP;
            default: m = MODE_SINGLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wib_edge_detect.sv
// Edge finder for a bundle of level inputs sampled in the system clock.
// Assumes: inputs are already synchronous to clk. The history resets to 0, so
// an input that is high out of reset reads as a rise.
module wib_edge_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_q;

    // Keeps the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign rise[i] = lvl[i] & ~lvl_q[i];
        assign fall[i] = ~lvl[i] & lvl_q[i];
    end
endmodule

// File: rtl/wib_fifo.sv
// Small overwrite-on-overflow queue with synchronous clear.
// Assumes: push and pop are single-cycle pulses; pop is only given when not
// empty. A push while full drops the oldest word; clear has priority.
module wib_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    head,
    output logic            empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          full;
    logic          adv_r;

    assign full  = (count == FULL);
    assign empty = (count == '0);
    assign head  = slot[rptr];
    // Read pointer moves on a pop, or on a push into a full queue.
    assign adv_r = pop | (push & full);

    // Writes the incoming word into the slot the write pointer names.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                    slot[s] <= '0;
            else if (push && !clear && wptr == PW'(s))     slot[s] <= din;
        end
    end

    // Steps both pointers with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push)  wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (adv_r) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Tracks occupancy; a full push keeps it at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)        count <= '0;
        else if (push && !pop && !full) count <= count + 1'b1;
        else if (pop && !push)      count <= count - 1'b1;
    end
endmodule

// File: rtl/wib_hold.sv
// Single-word storage for the two non-queue modes: an edge-triggered word
// register and a clocked model of a transparent latch.
// Assumes: wr_rise comes from the shared edge finder; the latch copy follows
// the input at every edge that sees the strobe low in transparent mode.
module wib_hold #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wib_pkg::wib_mode_e  mode,
    input  logic                wr_lvl,
    input  logic                wr_rise,
    input  logic [W-1:0]        din,
    output logic [W-1:0]        single_word,
    output logic [W-1:0]        transp_word
);
    import wib_pkg::*;

    logic [W-1:0] latch_q;

    // Captures the input word on a write edge in single word mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                               single_word <= '0;
        else if (mode == MODE_SINGLE && wr_rise)  single_word <= din;
    end

    // Follows the input while the strobe is low; freezes once it is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                               latch_q <= '0;
        else if (mode == MODE_TRANSP && !wr_lvl)  latch_q <= din;
    end

    // Open latch passes the live input, closed latch gives the held copy.
    always_comb transp_word = wr_lvl ? latch_q : din;
endmodule

// File: rtl/word_input_buffer.sv
// Input word buffer for a pixel shifter. Decodes the mode pins, finds strobe
// edges, steers writes into the queue or the single-word stores, and
// registers the selected word for the shifter's parallel load.
// Assumes: all inputs are synchronous to clk; the result is registered one
// edge after the sampled load rise.
module word_input_buffer #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_a,
    input  logic         mode_b,
    input  logic         wr_strobe,
    input  logic [W-1:0] wr_data,
    input  logic         load_req,
    output logic [W-1:0] load_word,
    output logic         load_pulse
);
    import wib_pkg::*;

    localparam int CW = $clog2(DEPTH+1);
    localparam int LN_WR = 0;
    localparam int LN_RD = 1;
    localparam int LN_MB = 2;

    wib_mode_e      mode;
    logic [2:0]     rise, fall;
    logic           wr_rise, rd_rise, fifo_mode, fifo_clear;
    logic           q_push, q_pop, q_empty;
    logic [W-1:0]   q_head, single_word, transp_word;
    logic [CW-1:0]  q_count;

    assign mode      = wib_decode(mode_a, mode_b);
    assign fifo_mode = (mode == MODE_FIFO);

    wib_edge_detect #(.N(3)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({mode_b, load_req, wr_strobe}),
        .rise (rise),
        .fall (fall)
    );

    assign wr_rise    = rise[LN_WR];
    assign rd_rise    = rise[LN_RD];
    // Queue clear: second mode pin falls out of queue mode with the load request high.
    assign fifo_clear = mode_a & fall[LN_MB] & load_req;
    assign q_push     = fifo_mode & wr_rise;
    assign q_pop      = fifo_mode & rd_rise & ~q_empty;

    wib_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(fifo_clear),
        .push (q_push),
        .pop  (q_pop),
        .din  (wr_data),
        .head (q_head),
        .empty(q_empty),
        .count(q_count)
    );

    wib_hold #(.W(W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .wr_lvl     (wr_strobe),
        .wr_rise    (wr_rise),
        .din        (wr_data),
        .single_word(single_word),
        .transp_word(transp_word)
    );

    // Loads the word chosen by the mode on a load edge; empty queue keeps the old word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_word <= '0;
        end else if (rd_rise) begin
            case (mode)
                MODE_FIFO:   if (!q_empty) load_word <= q_head;
                MODE_TRANSP: load_word <= transp_word;
                default:     load_word <= single_word;
            endcase
        end
    end

    // Marks each delivery for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) load_pulse <= 1'b0;
        else        load_pulse <= rd_rise;
    end
endmodule

// File: rtl/word_input_buffer_chk.sv
// Property checker for the input word buffer, attached by bind.
module word_input_buffer_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_req,
    input logic                       load_pulse,
    input logic [W-1:0]               load_word,
    input logic                       fifo_mode,
    input logic                       wr_rise,
    input logic                       rd_rise,
    input logic                       fifo_clear,
    input logic [$clog2(DEPTH+1)-1:0] q_count
);
    // R11: a delivery pulse lasts one cycle.
    a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);

    // R11: every pulse follows a sampled high load request.
    a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> $past(load_req));

    // R11: the word moves only together with a pulse.
    a_r11_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |-> $stable(load_word));

    // R4: occupancy never passes the depth; a full write keeps it full.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= ($clog2(DEPTH+1))'(DEPTH));

    a_r4_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && wr_rise && !rd_rise && !fifo_clear &&
         q_count == ($clog2(DEPTH+1))'(DEPTH)) |=> q_count == ($clog2(DEPTH+1))'(DEPTH));

    // R5: a read of an empty queue leaves the delivered word alone.
    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rd_rise && q_count == '0) |=> $stable(load_word));

    // R6: a clear leaves the queue empty.
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> q_count == '0);

    // R3: a lone read takes exactly one word.
    a_r3_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rd_rise && !wr_rise && !fifo_clear && q_count != '0)
        |=> q_count == $past(q_count) - 1'b1);
endmodule

bind word_input_buffer word_input_buffer_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .load_pulse(load_pulse),
    .load_word (load_word),
    .fifo_mode (fifo_mode),
    .wr_rise   (wr_rise),
    .rd_rise   (rd_rise),
    .fifo_clear(fifo_clear),
    .q_count   (q_count)
);

// File: tb/word_input_buffer_tb.sv
module word_input_buffer_tb;
    localparam int W  = 16;
    localparam int NV = 35;

    typedef struct packed {
        logic         m_a;
        logic         m_b;
        logic         wr;
        logic         rd;
        logic [15:0]  din;
        logic         chk;
        logic [15:0]  exp;
        logic [3:0]   req;
    } vec_t;

    // Queue-mode walk: R1 reset view, R3 order, R5 empty reads, R4 overflow.
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h0000,4'd1},
        '{1'b1,1'b1,1'b1,1'b0,16'h1111,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b1,1'b0,16'h2222,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'h1111,4'd3},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h1111,4'd3},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'h2222,4'd3},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'h2222,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd5},
        '{1'b1,1'b1,1'b1,1'b1,16'h3333,1'b1,16'h2222,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,16'h2222,4'd5},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'h3333,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd5},
        '{1'b1,1'b1,1'b1,1'b0,16'hA001,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b1,1'b0,16'hA002,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b1,1'b0,16'hA003,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b1,1'b0,16'hA004,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b1,1'b0,16'hA005,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hA002,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hA003,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hA004,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hA005,4'd4},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,16'hA005,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000,4'd5}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_a = 1'b1, mode_b = 1'b1, wr_strobe = 1'b0, load_req = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] load_word;
    logic         load_pulse;
    int           checks = 0, failures = 0;

    always #10 clk = ~clk;

    word_input_buffer #(.W(W), .DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .load_req(load_req),
        .load_word(load_word), .load_pulse(load_pulse)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies inputs at a falling edge and returns at the next falling edge.
    task automatic step(input logic a, input logic b, input logic wr, input logic rd,
                        input logic [W-1:0] d);
        mode_a = a; mode_b = b; wr_strobe = wr; load_req = rd; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", load_word, '0);
        check("R1 reset pulse", {15'd0, load_pulse}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].m_a, TBL[i].m_b, TBL[i].wr, TBL[i].rd, TBL[i].din);
            if (TBL[i].chk) check($sformatf("R%0d row %0d", TBL[i].req, i), load_word, TBL[i].exp);
        end

        // R10: held write strobe stores once.
        step(1,1,1,0,16'hB001);
        step(1,1,1,0,16'hB002);
        step(1,1,0,0,16'h0000);
        step(1,1,0,1,16'h0000);
        check("R10 first read", load_word, 16'hB001);
        step(1,1,0,0,16'h0000);
        step(1,1,0,1,16'h0000);
        check("R10 only one stored", load_word, 16'hB001);
        // R10: held load request delivers once.
        step(1,1,1,0,16'hB003);
        step(1,1,0,1,16'h0000);
        step(1,1,0,1,16'h0000);
        check("R10 held load no second pulse", {15'd0, load_pulse}, 16'd0);

        // R6: clear with load request high empties the queue.
        step(1,1,0,0,16'h0000);
        step(1,1,1,0,16'hC001);
        step(1,1,0,0,16'h0000);
        step(1,1,1,0,16'hC002);
        step(1,1,0,1,16'h0000);
        check("R6 pre-clear read", load_word, 16'hC001);
        step(1,0,0,1,16'h0000);
        step(1,1,0,1,16'h0000);
        step(1,1,0,0,16'h0000);
        step(1,1,0,1,16'h0000);
        check("R6 cleared queue keeps word", load_word, 16'hC001);
        // R6: same pulse with load request low keeps contents.
        step(1,1,0,0,16'h0000);
        step(1,1,1,0,16'hD001);
        step(1,1,0,0,16'h0000);
        step(1,0,0,0,16'h0000);
        step(1,1,0,0,16'h0000);
        step(1,1,0,1,16'h0000);
        check("R6 no clear when load low", load_word, 16'hD001);

        // R7: single word register.
        step(0,0,0,0,16'h0000);
        step(0,0,1,0,16'hE001);
        step(0,0,0,0,16'hFFFF);
        step(0,0,0,1,16'hFFFF);
        check("R7 captured word", load_word, 16'hE001);
        check("R11 pulse high", {15'd0, load_pulse}, 16'd1);
        step(0,0,0,0,16'hFFFF);
        check("R11 pulse one cycle", {15'd0, load_pulse}, 16'd0);
        step(0,0,1,1,16'hE002);
        check("R7 same-cycle gives previous", load_word, 16'hE001);
        step(0,0,0,0,16'h0000);
        step(0,0,0,1,16'h0000);
        check("R7 new word", load_word, 16'hE002);

        // R8: transparent while strobe low.
        step(1,0,0,0,16'hF001);
        step(1,0,0,1,16'hF001);
        check("R8 pass through", load_word, 16'hF001);
        step(1,0,0,0,16'hF002);
        step(1,0,0,1,16'hF002);
        check("R8 follows input", load_word, 16'hF002);

        // R9: latch closes when strobe rises.
        step(1,0,0,0,16'hF003);
        step(1,0,1,0,16'hF004);
        step(1,0,1,1,16'hF004);
        check("R9 latched word", load_word, 16'hF003);
        step(1,0,1,0,16'hF005);
        step(1,0,1,1,16'hF005);
        check("R9 latch held", load_word, 16'hF003);

        // R2: unused code acts as single word register, not transparent.
        step(0,1,0,0,16'h0000);
        step(0,1,1,0,16'h6001);
        step(0,1,0,0,16'h0000);
        step(0,1,0,1,16'h0000);
        check("R2 unused code single", load_word, 16'h6001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule